// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block keeps one direct-mapped cache coherent with its peers on a shared bus. Every line carries a tag, a data word and one of four coherence states: Invalid, Shared (several caches hold it, memory is current), Exclusive (only this cache holds it, memory is current) and Modified (only this cache holds it, memory is stale). Processor reads and writes are resolved against these states. The block issues a bus transaction only when coherence requires one. Those transactions are: a fill read, a read-for-ownership, an address-only invalidate, and a write-back.

In parallel the block watches transactions that other caches put on the bus. It answers a snooped access in the same cycle through two signals. One is a shared indication. The other is a retry, raised when the snoop hits a line held here as Modified. After a retry the block pushes the dirty line out to memory before it starts any new work of its own. When its own fill is retried by a peer, it waits, then issues the fill again, and only then completes the processor access. The bus is treated as atomic: a snoop never arrives while this block has a request outstanding. Arbitration and memory sit outside and are seen through a request/acknowledge handshake.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, busReq and cpuDone are low, and a snoop of any address gets neither snpRetry nor snpShared.
- R2: A read miss issues busCmd 0 (fill read) for the requested address. The line becomes Exclusive when busSharedIn is low at the acknowledge, and Shared when it is high. The word on busRdata is returned on cpuRdata.
- R3: A read hit in any valid state, and a write hit on an Exclusive or Modified line, complete with no bus request. A write hit leaves the line Modified and holding the new word.
- R4: A write hit on a Shared line issues busCmd 2 (address-only invalidate) for that address before completing, and leaves the line Modified.
- R5: A write miss issues busCmd 1 (read-for-ownership), installs the written word and leaves the line Modified.
- R6: A miss whose victim line is Modified first issues busCmd 3 (write-back) with the victim's address and data. A clean victim is dropped with no bus transaction.
- R7: A snooped fill read (snpCmd 0) that hits an Exclusive or Shared line raises snpShared in the same cycle and leaves the line Shared.
- R8: A snooped read-for-ownership (snpCmd 1) hitting a clean line, or a snooped invalidate (snpCmd 2) hitting any valid line, makes the line Invalid without retry.
- R9: A snooped fill read or read-for-ownership that hits a Modified line raises snpRetry in that cycle. The next bus request is then a write-back of that line, after which the line is Shared (for a snooped read) or Invalid (for a snooped ownership read).
- R10: When the block's own fill read or read-for-ownership is answered with busRetryIn, cpuDone stays low and the same command is issued again later. The access completes only after an acknowledge.
- R11: cpuDone is a one-cycle pulse per access. While busReq is high and no acknowledge or retry has arrived, busCmd and busAddr hold steady.
- R12: A snoop that misses (Invalid line or different tag), and any snooped write-back (snpCmd 3), produce no response and change no line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Processor access request, held until cpuDone |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address of the access |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Read data, valid with cpuDone |
| cpuDone | output | 1 | One-cycle completion pulse |
| busReq | output | 1 | Bus transaction request |
| busCmd | output | 2 | 0 fill read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| busAddr | output | ADDR_W | Transaction address |
| busWdata | output | DATA_W | Write-back data |
| busAck | input | 1 | Transaction completed |
| busRetryIn | input | 1 | Transaction refused by a peer; reissue later |
| busSharedIn | input | 1 | A peer holds the line (sampled with busAck) |
| busRdata | input | DATA_W | Fill data (valid with busAck) |
| snpValid | input | 1 | A peer transaction is being snooped |
| snpCmd | input | 2 | Snooped command, same encoding as busCmd |
| snpAddr | input | ADDR_W | Snooped address |
| snpRetry | output | 1 | Snoop hit a Modified line; peer must retry |
| snpShared | output | 1 | Snooped read hit a clean local copy |

## Verification
The embedded properties watch, on every cycle, that a pending request holds its command and address, that completion is a single pulse, that a refused transaction never completes the access, and that a retry always leaves a push-out pending. They also check that a write-back only leaves for a Modified line and an invalidate only for a Shared one. What a property cannot see is the state each line ends up in and the data it returns. The bench covers these by keeping its own per-line MESI model and memory. It replays directed sequences (silent upgrade, retry-and-push-out, dirty and clean eviction, refused fill) and a seeded random mix of processor accesses and snoops, then compares each bus transaction, read word and snoop response against that model.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BC_READ = 2'd0,
    BC_RFO  = 2'd1,
    BC_INV  = 2'd2,
    BC_WB   = 2'd3
  } busCmd_t;

  typedef enum logic [2:0] {
    C_IDLE,
    C_PUSH,
    C_EVICT,
    C_FILL,
    C_UPG,
    C_RESP
  } ctrlState_t;

  // strobes from the processor-side control into the line store
  typedef struct packed {
    logic       stWr;
    logic       tagWr;
    logic       dataWr;
    logic       dataFromBus;
    lineState_t newState;
  } cpuStrobe_t;

  // strobes from the snoop responder into the line store
  typedef struct packed {
    logic       stWr;
    lineState_t newState;
  } snpStrobe_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  lkIdx,
  output lineState_t        lkState,
  output logic [TAG_W-1:0]  lkTag,
  output logic [DATA_W-1:0] lkData,
  input  logic [IDX_W-1:0]  snpIdx,
  output lineState_t        snpState,
  output logic [TAG_W-1:0]  snpTag,
  input  cpuStrobe_t        cs,
  input  snpStrobe_t        ss,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [DATA_W-1:0] busData
);

  lineState_t        stArr   [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  assign lkState  = stArr[lkIdx];
  assign lkTag    = tagArr[lkIdx];
  assign lkData   = dataArr[lkIdx];
  assign snpState = stArr[snpIdx];
  assign snpTag   = tagArr[snpIdx];

  // state bits: snoop and processor updates may land in the same cycle on
  // different lines; the processor side is ordered last
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) stArr[i] <= LS_I;
    end else begin
      if (ss.stWr) stArr[snpIdx] <= ss.newState;
      if (cs.stWr) stArr[lkIdx]  <= cs.newState;
    end
  end

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) begin
          tagArr[g]  <= '0;
          dataArr[g] <= '0;
        end else if (lkIdx == IDX_W'(g)) begin
          if (cs.tagWr)  tagArr[g]  <= wrTag;
          if (cs.dataWr) dataArr[g] <= cs.dataFromBus ? busData : cpuData;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic [IDX_W-1:0]  snpIdx,
  input  lineState_t        snpState,
  input  logic [TAG_W-1:0]  snpTag,
  output logic              snpRetry,
  output logic              snpShared,
  output snpStrobe_t        ss,
  input  logic              pushDone,
  output logic              pushPend,
  output logic [IDX_W-1:0]  pushIdx,
  output logic              pushKeep
);

  busCmd_t sCmd;
  logic    tagHit;
  logic    lineHit;
  logic    readLike;
  logic    dirtyHit;

  assign sCmd     = busCmd_t'(snpCmd);
  assign snpIdx   = snpAddr[IDX_W-1:0];
  assign tagHit   = (snpTag == snpAddr[ADDR_W-1:IDX_W]);
  assign lineHit  = snpValid && (snpState != LS_I) && tagHit;
  assign readLike = (sCmd == BC_READ) || (sCmd == BC_RFO);
  assign dirtyHit = lineHit && readLike && (snpState == LS_M);

  assign snpRetry  = dirtyHit;
  assign snpShared = lineHit && (sCmd == BC_READ) && (snpState != LS_M);

  always_comb begin
    ss = '0;
    ss.newState = LS_I;
    if (lineHit && !dirtyHit) begin
      unique case (sCmd)
        BC_READ: begin ss.stWr = 1'b1; ss.newState = LS_S; end
        BC_RFO,
        BC_INV:  begin ss.stWr = 1'b1; ss.newState = LS_I; end
        default: ss.stWr = 1'b0;
      endcase
    end
  end

  // one outstanding push-out; further dirty hits are simply retried again
  always_ff @(posedge clk) begin
    if (rst) begin
      pushPend <= 1'b0;
      pushIdx  <= '0;
      pushKeep <= 1'b0;
    end else if (pushDone) begin
      pushPend <= 1'b0;
    end else if (dirtyHit && !pushPend) begin
      pushPend <= 1'b1;
      pushIdx  <= snpIdx;
      pushKeep <= (sCmd == BC_READ);
    end
  end

  // R9: a retried snoop always leaves a push-out pending
  a_r9_retry_pends: assert property (@(posedge clk) disable iff (rst)
    snpRetry |=> pushPend);

endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuDone,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic              busRetryIn,
  input  logic              busSharedIn,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic              pushPend,
  input  logic [IDX_W-1:0]  pushIdx,
  input  logic              pushKeep,
  output logic              pushDone,
  output logic [IDX_W-1:0]  lkIdx,
  input  lineState_t        lkState,
  input  logic [TAG_W-1:0]  lkTag,
  input  logic [DATA_W-1:0] lkData,
  output cpuStrobe_t        cs
);

  ctrlState_t        st, nxt;
  logic [IDX_W-1:0]  cpuIdx;
  logic [TAG_W-1:0]  cpuTag;
  logic              cpuHit;
  logic              doneNext;
  logic [DATA_W-1:0] rdataNext;
  busCmd_t           cmdE;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign cpuHit = (lkState != LS_I) && (lkTag == cpuTag);
  assign busCmd = cmdE;

  always_comb begin
    nxt         = st;
    cs          = '0;
    cs.newState = LS_I;
    doneNext    = 1'b0;
    rdataNext   = cpuRdata;
    busReq      = 1'b0;
    cmdE        = BC_READ;
    busAddr     = cpuAddr;
    busWdata    = lkData;
    pushDone    = 1'b0;
    lkIdx       = cpuIdx;
    unique case (st)
      C_IDLE: begin
        // a snoop owns the line store this cycle; start nothing
        if (!snpValid) begin
          if (pushPend) begin
            nxt = C_PUSH;
          end else if (cpuReq) begin
            if (cpuHit) begin
              if (!cpuWrite) begin
                doneNext  = 1'b1;
                rdataNext = lkData;
                nxt       = C_RESP;
              end else if (lkState == LS_S) begin
                nxt = C_UPG;
              end else begin
                cs.stWr     = 1'b1;
                cs.newState = LS_M;
                cs.dataWr   = 1'b1;
                doneNext    = 1'b1;
                nxt         = C_RESP;
              end
            end else if (lkState == LS_M) begin
              nxt = C_EVICT;
            end else begin
              nxt = C_FILL;
            end
          end
        end
      end
      C_PUSH: begin
        lkIdx   = pushIdx;
        busReq  = 1'b1;
        cmdE    = BC_WB;
        busAddr = {lkTag, pushIdx};
        if (busAck) begin
          cs.stWr     = 1'b1;
          cs.newState = pushKeep ? LS_S : LS_I;
          pushDone    = 1'b1;
          nxt         = C_IDLE;
        end else if (busRetryIn) begin
          nxt = C_IDLE;
        end
      end
      C_EVICT: begin
        busReq  = 1'b1;
        cmdE    = BC_WB;
        busAddr = {lkTag, cpuIdx};
        if (busAck) begin
          cs.stWr     = 1'b1;
          cs.newState = LS_I;
          nxt         = C_FILL;
        end else if (busRetryIn) begin
          nxt = C_IDLE;
        end
      end
      C_FILL: begin
        busReq = 1'b1;
        cmdE   = cpuWrite ? BC_RFO : BC_READ;
        if (busAck) begin
          cs.stWr        = 1'b1;
          cs.tagWr       = 1'b1;
          cs.dataWr      = 1'b1;
          cs.dataFromBus = !cpuWrite;
          cs.newState    = cpuWrite ? LS_M : (busSharedIn ? LS_S : LS_E);
          doneNext       = 1'b1;
          if (!cpuWrite) rdataNext = busRdata;
          nxt            = C_RESP;
        end else if (busRetryIn) begin
          nxt = C_IDLE;
        end
      end
      C_UPG: begin
        busReq = 1'b1;
        cmdE   = BC_INV;
        if (busAck) begin
          cs.stWr     = 1'b1;
          cs.newState = LS_M;
          cs.dataWr   = 1'b1;
          doneNext    = 1'b1;
          nxt         = C_RESP;
        end else if (busRetryIn) begin
          nxt = C_IDLE;
        end
      end
      C_RESP:  nxt = C_IDLE;
      default: nxt = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= C_IDLE;
      cpuDone  <= 1'b0;
      cpuRdata <= '0;
    end else begin
      st       <= nxt;
      cpuDone  <= doneNext;
      cpuRdata <= rdataNext;
    end
  end

  // R11: a pending request keeps its command and address
  a_r11_req_stable: assert property (@(posedge clk) disable iff (rst)
    busReq && !busAck && !busRetryIn |=> busReq && $stable(busCmd) && $stable(busAddr));

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    cpuDone |=> !cpuDone);

  // R10: a refused transaction never completes the access
  a_r10_retry_no_done: assert property (@(posedge clk) disable iff (rst)
    busReq && busRetryIn |=> !cpuDone);

  // R9: a pending push-out is the first request to go out
  a_r9_push_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busReq) && pushPend |-> busCmd == BC_WB);

  // R6: only a Modified line is ever written back
  a_r6_wb_dirty: assert property (@(posedge clk) disable iff (rst)
    busReq && busCmd == BC_WB |-> lkState == LS_M);

  // R4: the address-only invalidate upgrades a Shared line
  a_r4_inv_shared: assert property (@(posedge clk) disable iff (rst)
    busReq && busCmd == BC_INV |-> lkState == LS_S && cpuReq && cpuWrite);

  // R5: ownership reads come only from processor writes
  a_r5_rfo_write: assert property (@(posedge clk) disable iff (rst)
    busReq && busCmd == BC_RFO |-> cpuReq && cpuWrite);

endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuDone,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic              busRetryIn,
  input  logic              busSharedIn,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpRetry,
  output logic              snpShared
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lkIdx, snpIdx, pushIdx;
  lineState_t        lkState, snpState;
  logic [TAG_W-1:0]  lkTag, snpTag;
  logic [DATA_W-1:0] lkData;
  cpuStrobe_t        cs;
  snpStrobe_t        ss;
  logic              pushPend, pushKeep, pushDone;

  mesi_line_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .lkIdx(lkIdx), .lkState(lkState), .lkTag(lkTag), .lkData(lkData),
    .snpIdx(snpIdx), .snpState(snpState), .snpTag(snpTag),
    .cs(cs), .ss(ss),
    .wrTag(cpuAddr[ADDR_W-1:IDX_W]), .cpuData(cpuWdata), .busData(busRdata)
  );

  mesi_snoop_unit #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_snoop (
    .clk(clk), .rst(rst),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpIdx(snpIdx), .snpState(snpState), .snpTag(snpTag),
    .snpRetry(snpRetry), .snpShared(snpShared), .ss(ss),
    .pushDone(pushDone), .pushPend(pushPend), .pushIdx(pushIdx), .pushKeep(pushKeep)
  );

  mesi_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuRdata(cpuRdata), .cpuDone(cpuDone),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRetryIn(busRetryIn), .busSharedIn(busSharedIn), .busRdata(busRdata),
    .snpValid(snpValid),
    .pushPend(pushPend), .pushIdx(pushIdx), .pushKeep(pushKeep), .pushDone(pushDone),
    .lkIdx(lkIdx), .lkState(lkState), .lkTag(lkTag), .lkData(lkData),
    .cs(cs)
  );

endmodule

// File: tb/mesi_cache_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_cache_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NL = 8;
  localparam int ST_I = 0, ST_S = 1, ST_E = 2, ST_M = 3;
  localparam int C_RD = 0, C_RFO = 1, C_INV = 2, C_WB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpuReq = 0, cpuWrite = 0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0, cpuRdata;
  logic cpuDone, busReq;
  logic [1:0] busCmd;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic busAck = 0, busRetryIn = 0, busSharedIn = 0;
  logic [DW-1:0] busRdata = '0;
  logic snpValid = 0;
  logic [1:0] snpCmd = '0;
  logic [AW-1:0] snpAddr = '0;
  logic snpRetry, snpShared;

  mesi_cache_ctrl u_mesi_cache_ctrl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuDone(cpuDone),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRetryIn(busRetryIn), .busSharedIn(busSharedIn), .busRdata(busRdata),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpRetry(snpRetry), .snpShared(snpShared)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [DW-1:0] mem [32];
  int mSt [NL];
  int mTag [NL];
  logic [DW-1:0] mData [NL];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit isHit(int a);
    return (mSt[a % NL] != ST_I) && (mTag[a % NL] == a / NL);
  endfunction

  task automatic cpuOp(input bit wr, input int a, input logic [DW-1:0] wd, input bit sh, input bit rty);
    int idx; int tg; int nExp; int gotN; int guard;
    int expCmd [4]; int expAdr [4]; logic [DW-1:0] expWd [4];
    logic [DW-1:0] expRd; string req; bit retried; bit miss;
    idx = a % NL; tg = a / NL; nExp = 0; gotN = 0; guard = 0; retried = 0;
    expRd = '0; miss = !isHit(a);
    if (!miss) begin
      if (!wr) begin req = "R3"; expRd = mData[idx]; end
      else if (mSt[idx] == ST_S) begin req = "R4"; expCmd[0] = C_INV; expAdr[0] = a; expWd[0] = '0; nExp = 1; end
      else req = "R3";
    end else begin
      req = wr ? "R5" : "R2";
      if (mSt[idx] == ST_M) begin
        expCmd[nExp] = C_WB; expAdr[nExp] = mTag[idx] * NL + idx; expWd[nExp] = mData[idx];
        nExp++; req = "R6";
      end
      expCmd[nExp] = wr ? C_RFO : C_RD; expAdr[nExp] = a; expWd[nExp] = '0; nExp++;
      if (rty) begin
        expCmd[nExp] = wr ? C_RFO : C_RD; expAdr[nExp] = a; expWd[nExp] = '0; nExp++; req = "R10";
      end
      expRd = mem[a];
    end
    @(negedge clk);
    cpuReq = 1; cpuWrite = wr; cpuAddr = AW'(a); cpuWdata = wd;
    @(negedge clk);
    while (!cpuDone && guard < 200) begin
      guard++;
      if (busReq) begin
        if (gotN < nExp)
          chk(busCmd == 2'(expCmd[gotN]) && busAddr == AW'(expAdr[gotN]) &&
              (busCmd != 2'(C_WB) || busWdata == expWd[gotN]),
              req, {14'd0, busCmd, busAddr}, {14'd0, 2'(expCmd[gotN]), AW'(expAdr[gotN])});
        else
          chk(0, req, {14'd0, busCmd, busAddr}, 32'hFFFF_FFFF);
        gotN++;
        repeat ($urandom % 3) @(negedge clk);
        if (rty && !retried && (busCmd == 2'(C_RD) || busCmd == 2'(C_RFO))) begin
          retried = 1; busRetryIn = 1;
        end else begin
          busAck = 1; busSharedIn = sh; busRdata = mem[busAddr[4:0]];
          if (busCmd == 2'(C_WB)) mem[busAddr[4:0]] = busWdata;
        end
        @(negedge clk);
        busAck = 0; busRetryIn = 0;
      end else begin
        @(negedge clk);
      end
    end
    chk(cpuDone == 1'b1, req, {31'd0, cpuDone}, 32'd1);
    chk(gotN == nExp, req, gotN, nExp);
    if (!wr) chk(cpuRdata == expRd, req, cpuRdata, expRd);
    cpuReq = 0;
    @(negedge clk);
    chk(cpuDone == 1'b0, "R11", {31'd0, cpuDone}, 32'd0);
    if (miss) begin
      mTag[idx] = tg;
      mSt[idx] = wr ? ST_M : (sh ? ST_S : ST_E);
      mData[idx] = wr ? wd : expRd;
    end else if (wr) begin
      mSt[idx] = ST_M;
      mData[idx] = wd;
    end
  endtask

  task automatic snoopOp(input int cmd, input int a);
    int idx; bit hit; bit eRetry; bit eShared; string req; int guard;
    idx = a % NL; hit = isHit(a); guard = 0;
    eRetry = hit && mSt[idx] == ST_M && (cmd == C_RD || cmd == C_RFO);
    eShared = hit && cmd == C_RD && mSt[idx] != ST_M;
    if (!hit || cmd == C_WB) req = "R12";
    else if (eRetry) req = "R9";
    else if (cmd == C_RD) req = "R7";
    else req = "R8";
    @(negedge clk);
    snpValid = 1; snpCmd = 2'(cmd); snpAddr = AW'(a);
    #1;
    chk(snpRetry == eRetry && snpShared == eShared, req,
        {30'd0, snpRetry, snpShared}, {30'd0, eRetry, eShared});
    @(negedge clk);
    snpValid = 0;
    if (hit && !eRetry) begin
      if (cmd == C_RD) mSt[idx] = ST_S;
      else if (cmd == C_RFO || cmd == C_INV) mSt[idx] = ST_I;
    end
    if (eRetry) begin
      while (!busReq && guard < 50) begin guard++; @(negedge clk); end
      chk(busReq && busCmd == 2'(C_WB) && busAddr == AW'(a) && busWdata == mData[idx], "R9",
          {14'd0, busCmd, busAddr}, {14'd0, 2'(C_WB), AW'(a)});
      busAck = 1; mem[busAddr[4:0]] = busWdata;
      @(negedge clk);
      busAck = 0;
      mSt[idx] = (cmd == C_RD) ? ST_S : ST_I;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) mem[i] = 32'hA000_0000 + i;
    for (int i = 0; i < NL; i++) begin mSt[i] = ST_I; mTag[i] = 0; mData[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: quiet after reset
    chk(busReq == 1'b0, "R1", {31'd0, busReq}, 32'd0);
    chk(cpuDone == 1'b0, "R1", {31'd0, cpuDone}, 32'd0);
    snpValid = 1; snpCmd = 2'(C_RD); snpAddr = 16'd3;
    #1;
    chk(!snpRetry && !snpShared, "R1", {30'd0, snpRetry, snpShared}, 32'd0);
    @(negedge clk);
    snpValid = 0;

    // directed corner cases
    cpuOp(0, 5, '0, 0, 0);              // R2 fill Exclusive
    cpuOp(1, 5, 32'h1111_0005, 0, 0);   // R3 silent E->M
    snoopOp(C_RD, 5);                   // R9 retry, push-out, Shared
    cpuOp(1, 5, 32'h2222_0005, 0, 0);   // R4 invalidate upgrade
    snoopOp(C_RFO, 5);                  // R9 retry, push-out, Invalid
    cpuOp(0, 13, '0, 1, 0);             // R2 fill Shared
    snoopOp(C_RD, 13);                  // R7 stays Shared
    cpuOp(1, 21, 32'h3333_0015, 0, 0);  // R5 clean victim dropped
    cpuOp(0, 29, '0, 0, 0);             // R6 dirty victim written back
    snoopOp(C_WB, 29);                  // R12 ignored
    snoopOp(C_RD, 28);                  // R12 miss
    snoopOp(C_RD, 29);                  // R7 E->S
    snoopOp(C_INV, 29);                 // R8 -> I
    cpuOp(0, 29, '0, 0, 1);             // R10 refused then acked
    cpuOp(1, 30, 32'h4444_001E, 0, 0);  // R5
    snoopOp(C_INV, 30);                 // R8 invalidate on Modified
    cpuOp(0, 30, '0, 0, 0);             // R2 miss confirms Invalid

    // seeded random mix
    for (int n = 0; n < 400; n++) begin
      int a;
      a = int'($urandom % 32);
      if (($urandom % 10) < 6)
        cpuOp(bit'($urandom % 2), a, $urandom, bit'($urandom % 2), ($urandom % 6) == 0);
      else
        snoopOp(int'($urandom % 4), a);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule